// File: doc/BRIEF.md
# Checkpoint and Recovery Sequencer

This block orders the steps that turn a running processor's state into a durable checkpoint in non-volatile memory, and brings that state back at power-up. Once a checkpoint starts, it runs to the end. The block asks the cache to write back every dirty block. It then asks the mapping cache to publish each redirected block location into the persistent mapping table. After that it asks the register file to save its contents. Finally it sends a single-cycle pulse that clears the read/write tracking filters and discards the pending new-location fields. Three events start a checkpoint: an explicit request, the mapping cache needing to evict an entry that holds both an old and a new location, and the rising edge of a low-battery warning.

After reset the sequencer restores the saved register image before the processor may run. While the processor runs and no checkpoint is pending, a background reclaimer walks the mapping table one index at a time. For each index it asks whether the block is redirected. If it is, and the mapping cache is not holding a fresh location for it, the reclaimer has the block copied home and then has the entry deleted. Deleting the entry also invalidates the cached copy and frees the slot. Every unit outside the block is reached through a request/acknowledge pair. A request stays high until its acknowledge is seen.

Top module: `ckpt_seq`

## Requirements
- R1: While reset is high and in the cycles after it, before any acknowledge, `restore_req_o` is 1. `cpu_run_o` and every other request and pulse output are 0.
- R2: No reclaim lookup is issued before restore completes. The cycle after `restore_ack_i` is seen, `restore_req_o` falls and `cpu_run_o` rises.
- R3: While running, `evict_dual_i` or `snap_req_i` at 1 starts a checkpoint. `flush_req_o` rises within two cycles and `cpu_run_o` is 0 from then until the checkpoint ends.
- R4: The phases run in the fixed order flush, commit, dump. Each next request rises the cycle after the previous acknowledge, and at most one request output is high in any cycle.
- R5: The cycle after `dump_ack_i`, `filt_clr_o` and `drop_new_o` are 1 for exactly one cycle. On the next cycle `cpu_run_o` returns to 1.
- R6: A 0-to-1 change of `low_batt_i` starts exactly one checkpoint. Keeping it at 1 afterwards starts no further checkpoint.
- R7: A raised phase request stays high until its acknowledge arrives. Dropping the trigger that started the checkpoint does not cancel it.
- R8: Reclaim requests start only while running. A reclaim step already raised when a checkpoint is requested is finished first and delays the flush. No reclaim request is raised during a checkpoint.
- R9: A lookup answered with `gc_remapped_i`=0, or with `gc_pinned_i`=1, leads to no copy. The next lookup is for the following index.
- R10: A lookup answered with `gc_remapped_i`=1 and `gc_pinned_i`=0 leads to a copy request and then a delete request, both at the same `gc_idx_o`. The next lookup is for the following index.
- R11: The reclaim index counts up from 0 and wraps from ENTRIES-1 (15 by default) to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| snap_req_i | input | 1 | Explicit checkpoint request (level) |
| evict_dual_i | input | 1 | Mapping cache must evict an entry holding old and new locations (level) |
| low_batt_i | input | 1 | Low-battery warning; its rising edge starts a checkpoint |
| restore_req_o | output | 1 | Request to reload the saved register image |
| restore_ack_i | input | 1 | Register image reloaded |
| cpu_run_o | output | 1 | Processor may execute |
| flush_req_o | output | 1 | Request to write back all dirty cache blocks |
| flush_ack_i | input | 1 | Write-back finished |
| commit_req_o | output | 1 | Request to publish new locations into the persistent table |
| commit_ack_i | input | 1 | Table update finished |
| dump_req_o | output | 1 | Request to save the processor registers |
| dump_ack_i | input | 1 | Registers saved |
| filt_clr_o | output | 1 | One-cycle clear of the read/write tracking filters |
| drop_new_o | output | 1 | One-cycle discard of all new-location fields |
| gc_look_req_o | output | 1 | Reclaim lookup request for `gc_idx_o` |
| gc_idx_o | output | IW | Mapping-table index under reclaim |
| gc_look_ack_i | input | 1 | Lookup answer valid |
| gc_remapped_i | input | 1 | Entry is redirected (with lookup ack) |
| gc_pinned_i | input | 1 | Mapping cache holds a new location for it (with lookup ack) |
| gc_copy_req_o | output | 1 | Request to copy the block back home |
| gc_copy_ack_i | input | 1 | Copy finished |
| gc_del_req_o | output | 1 | Request to delete entry, invalidate cached copy, free slot |
| gc_del_ack_i | input | 1 | Delete finished |

## Verification
The bench drops the trigger while the flush request waits unanswered. A sequencer that aborts would lower the flush request there. It also holds a reclaim lookup open while a checkpoint is requested. A design that ignores the pause would raise the flush with a reclaim request still in flight, or would issue lookups mid-checkpoint. Low battery is held high across and after a whole checkpoint, which exposes a level-sensitive trigger that loops forever. The reclaim walk covers every answer combination, including a pinned entry that must not be copied, and runs up to the wrap from index 15 to 0.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;
  typedef enum logic [2:0] {
    S_RESTORE, S_IDLE, S_DRAIN, S_FLUSH, S_COMMIT, S_DUMP, S_CLEAR
  } seq_st_e;

  typedef enum logic [1:0] {G_LOOK, G_COPY, G_DEL} gc_st_e;
endpackage

// File: rtl/ckpt_trig.sv
module ckpt_trig (
  input  logic clk,
  input  logic rst,
  input  logic snap_req,
  input  logic evict_dual,
  input  logic low_batt,
  input  logic take,
  output logic trig
);
  logic lb_prev, lb_pend, lb_rise;

  assign lb_rise = low_batt & ~lb_prev;
  assign trig    = snap_req | evict_dual | lb_pend | lb_rise;

  // a low-battery edge is remembered until a checkpoint actually starts
  always_ff @(posedge clk) begin
    if (rst) begin
      lb_prev <= 1'b0;
      lb_pend <= 1'b0;
    end else begin
      lb_prev <= low_batt;
      lb_pend <= (lb_pend | lb_rise) & ~take;
    end
  end
endmodule

// File: rtl/ckpt_fsm.sv
module ckpt_fsm
  import ckpt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic trig,
  input  logic gc_quiet,
  input  logic restore_ack,
  input  logic flush_ack,
  input  logic commit_ack,
  input  logic dump_ack,
  output logic restore_req,
  output logic flush_req,
  output logic commit_req,
  output logic dump_req,
  output logic clr_pulse,
  output logic cpu_run,
  output logic take,
  output logic gc_en
);
  seq_st_e st, nxt;

  always_comb begin
    nxt = st;
    unique case (st)
      S_RESTORE: if (restore_ack) nxt = S_IDLE;
      S_IDLE:    if (trig) nxt = gc_quiet ? S_FLUSH : S_DRAIN;
      S_DRAIN:   if (gc_quiet) nxt = S_FLUSH;
      S_FLUSH:   if (flush_ack) nxt = S_COMMIT;
      S_COMMIT:  if (commit_ack) nxt = S_DUMP;
      S_DUMP:    if (dump_ack) nxt = S_CLEAR;
      S_CLEAR:   nxt = S_IDLE;
      default:   nxt = S_IDLE;
    endcase
  end

  assign take  = (st == S_IDLE) && trig;
  assign gc_en = (st == S_IDLE) && !trig;

  // outputs are registered decodes of the next state
  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_RESTORE;
      restore_req <= 1'b1;
      flush_req   <= 1'b0;
      commit_req  <= 1'b0;
      dump_req    <= 1'b0;
      clr_pulse   <= 1'b0;
      cpu_run     <= 1'b0;
    end else begin
      st          <= nxt;
      restore_req <= (nxt == S_RESTORE);
      flush_req   <= (nxt == S_FLUSH);
      commit_req  <= (nxt == S_COMMIT);
      dump_req    <= (nxt == S_DUMP);
      clr_pulse   <= (nxt == S_CLEAR);
      cpu_run     <= (nxt == S_IDLE);
    end
  end
endmodule

// File: rtl/ckpt_gc.sv
module ckpt_gc
  import ckpt_pkg::*;
#(
  parameter  int ENTRIES = 16,
  localparam int IW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          look_ack,
  input  logic          remapped,
  input  logic          pinned,
  input  logic          copy_ack,
  input  logic          del_ack,
  output logic          look_req,
  output logic          copy_req,
  output logic          del_req,
  output logic [IW-1:0] idx,
  output logic          quiet
);
  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

  gc_st_e        st;
  logic [IW-1:0] idx_nxt;

  assign idx_nxt = (idx == LAST) ? '0 : idx + 1'b1;
  assign quiet   = !(look_req || copy_req || del_req);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= G_LOOK;
      idx      <= '0;
      look_req <= 1'b0;
      copy_req <= 1'b0;
      del_req  <= 1'b0;
    end else if (quiet) begin
      // a new step only begins while the sequencer allows it
      if (en) begin
        unique case (st)
          G_LOOK:  look_req <= 1'b1;
          G_COPY:  copy_req <= 1'b1;
          default: del_req  <= 1'b1;
        endcase
      end
    end else begin
      if (look_req && look_ack) begin
        look_req <= 1'b0;
        if (remapped && !pinned) st <= G_COPY;
        else                     idx <= idx_nxt;
      end
      if (copy_req && copy_ack) begin
        copy_req <= 1'b0;
        st       <= G_DEL;
      end
      if (del_req && del_ack) begin
        del_req <= 1'b0;
        st      <= G_LOOK;
        idx     <= idx_nxt;
      end
    end
  end
endmodule

// File: rtl/ckpt_seq.sv
module ckpt_seq #(
  parameter  int ENTRIES = 16,
  localparam int IW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          snap_req_i,
  input  logic          evict_dual_i,
  input  logic          low_batt_i,
  output logic          restore_req_o,
  input  logic          restore_ack_i,
  output logic          cpu_run_o,
  output logic          flush_req_o,
  input  logic          flush_ack_i,
  output logic          commit_req_o,
  input  logic          commit_ack_i,
  output logic          dump_req_o,
  input  logic          dump_ack_i,
  output logic          filt_clr_o,
  output logic          drop_new_o,
  output logic          gc_look_req_o,
  output logic [IW-1:0] gc_idx_o,
  input  logic          gc_look_ack_i,
  input  logic          gc_remapped_i,
  input  logic          gc_pinned_i,
  output logic          gc_copy_req_o,
  input  logic          gc_copy_ack_i,
  output logic          gc_del_req_o,
  input  logic          gc_del_ack_i
);
  logic trig, take, gc_en, gc_quiet, clr_pulse;

  ckpt_trig u_trig (
    .clk        (clk),
    .rst        (rst),
    .snap_req   (snap_req_i),
    .evict_dual (evict_dual_i),
    .low_batt   (low_batt_i),
    .take       (take),
    .trig       (trig)
  );

  ckpt_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .trig        (trig),
    .gc_quiet    (gc_quiet),
    .restore_ack (restore_ack_i),
    .flush_ack   (flush_ack_i),
    .commit_ack  (commit_ack_i),
    .dump_ack    (dump_ack_i),
    .restore_req (restore_req_o),
    .flush_req   (flush_req_o),
    .commit_req  (commit_req_o),
    .dump_req    (dump_req_o),
    .clr_pulse   (clr_pulse),
    .cpu_run     (cpu_run_o),
    .take        (take),
    .gc_en       (gc_en)
  );

  ckpt_gc #(.ENTRIES(ENTRIES)) u_gc (
    .clk      (clk),
    .rst      (rst),
    .en       (gc_en),
    .look_ack (gc_look_ack_i),
    .remapped (gc_remapped_i),
    .pinned   (gc_pinned_i),
    .copy_ack (gc_copy_ack_i),
    .del_ack  (gc_del_ack_i),
    .look_req (gc_look_req_o),
    .copy_req (gc_copy_req_o),
    .del_req  (gc_del_req_o),
    .idx      (gc_idx_o),
    .quiet    (gc_quiet)
  );

  assign filt_clr_o = clr_pulse;
  assign drop_new_o = clr_pulse;
endmodule

// File: rtl/ckpt_seq_chk.sv
module ckpt_seq_chk #(
  parameter  int ENTRIES = 16,
  localparam int IW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic          restore_req_o,
  input logic          cpu_run_o,
  input logic          flush_req_o,
  input logic          flush_ack_i,
  input logic          commit_req_o,
  input logic          commit_ack_i,
  input logic          dump_req_o,
  input logic          dump_ack_i,
  input logic          filt_clr_o,
  input logic          gc_look_req_o,
  input logic [IW-1:0] gc_idx_o,
  input logic          gc_look_ack_i,
  input logic          gc_remapped_i,
  input logic          gc_pinned_i,
  input logic          gc_copy_req_o,
  input logic          gc_del_req_o
);
  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

  p_one_req_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({restore_req_o, flush_req_o, commit_req_o, dump_req_o,
              gc_look_req_o, gc_copy_req_o, gc_del_req_o}));

  p_commit_after_flush_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(commit_req_o) |-> $past(flush_ack_i));

  p_dump_after_commit_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(dump_req_o) |-> $past(commit_ack_i));

  p_flush_hold_r7: assert property (@(posedge clk) disable iff (rst)
    flush_req_o && !flush_ack_i |=> flush_req_o);

  p_commit_hold_r7: assert property (@(posedge clk) disable iff (rst)
    commit_req_o && !commit_ack_i |=> commit_req_o);

  p_dump_hold_r7: assert property (@(posedge clk) disable iff (rst)
    dump_req_o && !dump_ack_i |=> dump_req_o);

  p_clr_cause_r5: assert property (@(posedge clk) disable iff (rst)
    filt_clr_o |-> $past(dump_req_o && dump_ack_i));

  p_clr_single_r5: assert property (@(posedge clk) disable iff (rst)
    filt_clr_o |=> !filt_clr_o);

  p_gc_start_idle_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(gc_look_req_o) || $rose(gc_copy_req_o) || $rose(gc_del_req_o)
      |-> cpu_run_o);

  p_skip_advance_r9: assert property (@(posedge clk) disable iff (rst)
    gc_look_req_o && gc_look_ack_i && (!gc_remapped_i || gc_pinned_i)
      |=> gc_idx_o == (($past(gc_idx_o) == LAST) ? '0 : $past(gc_idx_o) + 1'b1));
endmodule

bind ckpt_seq ckpt_seq_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .restore_req_o (restore_req_o),
  .cpu_run_o     (cpu_run_o),
  .flush_req_o   (flush_req_o),
  .flush_ack_i   (flush_ack_i),
  .commit_req_o  (commit_req_o),
  .commit_ack_i  (commit_ack_i),
  .dump_req_o    (dump_req_o),
  .dump_ack_i    (dump_ack_i),
  .filt_clr_o    (filt_clr_o),
  .gc_look_req_o (gc_look_req_o),
  .gc_idx_o      (gc_idx_o),
  .gc_look_ack_i (gc_look_ack_i),
  .gc_remapped_i (gc_remapped_i),
  .gc_pinned_i   (gc_pinned_i),
  .gc_copy_req_o (gc_copy_req_o),
  .gc_del_req_o  (gc_del_req_o)
);

// File: tb/sim_ckpt_seq.sv
`timescale 1ns/1ps
module sim_ckpt_seq;
  localparam int ENTRIES = 16;
  localparam int IW = $clog2(ENTRIES);
  // reclaim answers {remapped, pinned}; a copy is due only for 2'b10
  localparam logic [1:0] VEC [6] = '{2'b00, 2'b10, 2'b11, 2'b01, 2'b10, 2'b00};

  logic clk = 0;
  logic rst = 1;
  logic snap_req = 0, evict_dual = 0, low_batt = 0;
  logic restore_ack = 0, flush_ack = 0, commit_ack = 0, dump_ack = 0;
  logic restore_req, cpu_run, flush_req, commit_req, dump_req, filt_clr, drop_new;
  logic look_req, copy_req, del_req, look_ack, remapped, pinned, copy_ack, del_ack;
  logic [IW-1:0] idx;
  logic gc_auto = 1;
  logic m_look = 0, m_rem = 0, m_pin = 0, m_copy = 0, m_del = 0;
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign look_ack = gc_auto ? look_req : m_look;
  assign remapped = gc_auto ? 1'b0 : m_rem;
  assign pinned   = gc_auto ? 1'b0 : m_pin;
  assign copy_ack = gc_auto ? copy_req : m_copy;
  assign del_ack  = gc_auto ? del_req : m_del;

  ckpt_seq #(.ENTRIES(ENTRIES)) u0 (
    .clk(clk), .rst(rst), .snap_req_i(snap_req), .evict_dual_i(evict_dual),
    .low_batt_i(low_batt), .restore_req_o(restore_req), .restore_ack_i(restore_ack),
    .cpu_run_o(cpu_run), .flush_req_o(flush_req), .flush_ack_i(flush_ack),
    .commit_req_o(commit_req), .commit_ack_i(commit_ack), .dump_req_o(dump_req),
    .dump_ack_i(dump_ack), .filt_clr_o(filt_clr), .drop_new_o(drop_new),
    .gc_look_req_o(look_req), .gc_idx_o(idx), .gc_look_ack_i(look_ack),
    .gc_remapped_i(remapped), .gc_pinned_i(pinned), .gc_copy_req_o(copy_req),
    .gc_copy_ack_i(copy_ack), .gc_del_req_o(del_req), .gc_del_ack_i(del_ack)
  );

  task automatic chk(string rq, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic logic sig(int c);
    case (c)
      1: return flush_req;
      5: return look_req;
      6: return copy_req;
      7: return del_req;
      default: return 1'b0;
    endcase
  endfunction

  task automatic wait_hi(int c, int maxc, output bit ok);
    ok = 0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (sig(c)) begin ok = 1; break; end
    end
  endtask

  // flush_req is high at the current negedge; answer every phase at once
  task automatic finish_snap(string rq);
    flush_ack = 1;
    @(negedge clk); flush_ack = 0;
    chk({rq, " R4 commit after flush"}, commit_req, 1);
    chk({rq, " R4 flush dropped"}, flush_req, 0);
    commit_ack = 1;
    @(negedge clk); commit_ack = 0;
    chk({rq, " R4 dump after commit"}, dump_req, 1);
    chk({rq, " R4 commit dropped"}, commit_req, 0);
    dump_ack = 1;
    @(negedge clk); dump_ack = 0;
    chk({rq, " R5 filter clear"}, filt_clr, 1);
    chk({rq, " R5 drop new"}, drop_new, 1);
    chk({rq, " R5 halted during clear"}, cpu_run, 0);
    @(negedge clk);
    chk({rq, " R5 clear single"}, filt_clr, 0);
    chk({rq, " R5 run again"}, cpu_run, 1);
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    report();
  end

  initial begin
    bit ok;
    int exp_idx;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 restore req", restore_req, 1);
    chk("R1 run low", cpu_run, 0);
    chk("R1 flush low", flush_req, 0);
    chk("R1 clear low", filt_clr, 0);
    repeat (4) @(negedge clk);
    chk("R2 no lookup before restore", look_req, 0);
    chk("R2 restore held", restore_req, 1);
    restore_ack = 1;
    @(negedge clk); restore_ack = 0;
    chk("R2 restore dropped", restore_req, 0);
    chk("R2 run", cpu_run, 1);

    // dual-location eviction, trigger dropped before the flush is answered
    evict_dual = 1;
    wait_hi(1, 4, ok);
    chk("R3 evict starts flush", ok, 1);
    chk("R3 halted", cpu_run, 0);
    evict_dual = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R7 flush held", flush_req, 1);
      chk("R4 no early commit", commit_req, 0);
    end
    finish_snap("evict");

    snap_req = 1;
    wait_hi(1, 4, ok);
    chk("R3 request starts flush", ok, 1);
    snap_req = 0;
    finish_snap("request");

    // low battery held high: one checkpoint only
    low_batt = 1;
    wait_hi(1, 4, ok);
    chk("R6 low battery starts flush", ok, 1);
    finish_snap("lowbatt");
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk("R6 no repeat", flush_req, 0);
    end
    low_batt = 0;
    repeat (3) @(negedge clk);
    chk("R6 fall no start", flush_req, 0);

    // reclaim step open when a checkpoint is requested
    gc_auto = 0;
    wait_hi(5, 6, ok);
    chk("R8 lookup while idle", ok, 1);
    snap_req = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R8 flush waits", flush_req, 0);
      chk("R8 lookup held", look_req, 1);
    end
    m_look = 1; m_rem = 0;
    @(negedge clk); m_look = 0;
    wait_hi(1, 3, ok);
    chk("R8 flush after reclaim step", ok, 1);
    snap_req = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R8 no lookup in checkpoint", look_req, 0);
      chk("R8 no copy in checkpoint", copy_req, 0);
    end
    finish_snap("paused");

    // table walk of lookup answers
    wait_hi(5, 4, ok);
    exp_idx = idx;
    for (int v = 0; v < 6; v++) begin
      if (v > 0) wait_hi(5, 4, ok);
      chk("R10 lookup seen", ok, 1);
      chk("R10 index sequence", idx, exp_idx);
      m_rem = VEC[v][1]; m_pin = VEC[v][0]; m_look = 1;
      @(negedge clk); m_look = 0;
      if (VEC[v] == 2'b10) begin
        wait_hi(6, 4, ok);
        chk("R10 copy issued", ok, 1);
        chk("R10 copy index", idx, exp_idx);
        m_copy = 1;
        @(negedge clk); m_copy = 0;
        wait_hi(7, 4, ok);
        chk("R10 delete issued", ok, 1);
        chk("R10 delete index", idx, exp_idx);
        m_del = 1;
        @(negedge clk); m_del = 0;
      end else begin
        chk("R9 no copy on skip", copy_req, 0);
      end
      exp_idx = (exp_idx + 1) % ENTRIES;
    end

    // walk to the last index and check the wrap
    m_rem = 0; m_pin = 0;
    for (int i = 0; i < 20; i++) begin
      wait_hi(5, 4, ok);
      if (idx == IW'(ENTRIES - 1)) begin
        m_look = 1;
        @(negedge clk); m_look = 0;
        wait_hi(5, 4, ok);
        chk("R11 wrap to zero", idx, 0);
        break;
      end
      m_look = 1;
      @(negedge clk); m_look = 0;
    end
    chk("R11 reached last index", ok, 1);
    report();
  end
endmodule